// File: doc/BRIEF.md
# Management Stream Compressor with Status Append

This block sits between a repeater core and a statistics controller on a serial NRZ management bus. The core delivers the data of a repeated packet one bit per clock, after a start-of-frame marker. The block passes those bits on as serial data with a qualifying receive-clock enable and a carrier-sense line. When the packet ends, it appends a 7-byte status word taken from the core. A management agent can raise a compress request while the packet is being repeated. The block then stops clocking data out once a programmed number of bytes has gone past the marker. This keeps only the address part of uninteresting frames and saves buffer space in the controller.

The controller is a four-state machine. `S_IDLE` waits for the frame marker and moves to `S_PASS` when `frm_sfd` is high. `S_PASS` forwards data bits. It moves to `S_HOLD` when a data bit arrives exactly at the programmed byte boundary while compression is armed, and it moves to `S_STAT` on `rx_end`. `S_HOLD` discards the rest of the packet with carrier sense held high, and moves to `S_STAT` on `rx_end`. `S_STAT` shifts out the 56 status bits and returns to `S_IDLE` after the last one. All outputs are registered, so each forwarded bit appears on the cycle after it was presented. The cycle on which `rx_end` is taken carries no clock pulse.

Top module: `ms_compressor`

## Requirements
- R1: After `rx_end`, exactly 56 clock-enabled bits of `stat_word` are sent, whether or not the packet was compressed. The status word is captured on the `rx_end` cycle.
- R2: Bits go out least significant first. Data bits keep the order in which they were received. Status bits go out starting at `stat_word[0]` and ending at `stat_word[55]`.
- R3: If compression is armed and a data bit arrives when exactly `cmp_dec` whole bytes have been forwarded since the frame marker, that bit and all later data bits of the frame get no clock pulse. This applies to any `cmp_dec` value, including 0.
- R4: If the packet ends before the programmed boundary is reached, or no request is made, every received data bit is forwarded. The status bits follow directly with no extra data.
- R5: While compression suppresses data, `mcrs` stays high and `mrx_clk_en` stays low until the status field starts.
- R6: A request first seen after the boundary has been passed has no effect on that frame. The boundary counts as passed once the first bit after `cmp_dec` whole bytes has been forwarded. A request seen in the same cycle as that first bit is still on time.
- R7: The forwarded-byte count saturates at its maximum (255 by default) and never wraps. A frame longer than that, whose request came after the boundary, is forwarded whole.
- R8: A request seen on time is latched for the rest of the frame. A one-cycle pulse compresses the frame just as a held level does. The latch clears at the next frame marker.
- R9: `mcrs` rises on the cycle after the frame marker is taken and stays high until the last status bit has been clocked. Whenever `mrx_clk_en` is high, `mcrs` is high.
- R10: During and after reset, `mrx_clk_en`, `mrx_dat` and `mcrs` are low.
- R11: Data cycles with `rx_vld` low produce no clock pulse. `mrx_dat` is 0 in every cycle without a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock (one NRZ bit per cycle) |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_sfd | input | 1 | One-cycle frame marker. Data bits follow from the next cycle |
| rx_vld | input | 1 | A data bit is present on `rx_bit` this cycle |
| rx_bit | input | 1 | Received data bit, LSB of each byte first |
| rx_end | input | 1 | One-cycle end-of-repetition pulse, in a cycle without data |
| cmp_req | input | 1 | Compress request from the management agent |
| cmp_dec | input | CNT_W | Number of bytes after the marker to keep when compressing |
| stat_word | input | 8*STAT_BYTES | Status word appended after the packet, byte 0 in bits 7:0 |
| mrx_clk_en | output | 1 | Receive-clock enable, high for each transferred bit |
| mrx_dat | output | 1 | Serial NRZ data qualified by `mrx_clk_en` |
| mcrs | output | 1 | Management carrier sense |

## Verification
The hardest cases to reach are the timing of the compress request against the byte boundary. A request on the exact boundary bit must compress, and a request one bit later must not. The stimulus places the request at chosen bit offsets within the frame to cover both cases. It also uses a one-cycle pulse to cover latching. Two cases drive longer frames: one with gaps in `rx_vld`, and one of 300 bytes with the request after the saturated boundary. A behavioural model in the bench predicts every output on every cycle. At each carrier drop, the bench also checks the total count of clocked bits, the first data byte and the rebuilt status word.

// File: rtl/ms_pkg.sv
package ms_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_PASS = 2'd1,
        S_HOLD = 2'd2,
        S_STAT = 2'd3
    } ms_state_e;
endpackage

// File: rtl/ms_bytecnt.sv
module ms_bytecnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    output logic [2:0]       bit_idx,
    output logic [CNT_W-1:0] byte_cnt
);
    logic sat;
    assign sat = &byte_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            bit_idx  <= '0;
            byte_cnt <= '0;
        end else if (adv) begin
            bit_idx <= bit_idx + 3'd1;
            if (bit_idx == 3'd7 && !sat)
                byte_cnt <= byte_cnt + 1'b1;
        end
    end

    // R7: once saturated the count never wraps
    a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (sat && !clr) |=> (&byte_cnt));
endmodule

// File: rtl/ms_cmpctl.sv
module ms_cmpctl #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             active,
    input  logic             adv,
    input  logic             req,
    input  logic [2:0]       bit_idx,
    input  logic [CNT_W-1:0] byte_cnt,
    input  logic [CNT_W-1:0] dec,
    output logic             hit
);
    logic lat_q;
    logic passed_q;
    logic at_dec;

    assign at_dec = (bit_idx == 3'd0) && (byte_cnt == dec);
    assign hit    = at_dec && (lat_q || (req && !passed_q));

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            lat_q    <= 1'b0;
            passed_q <= 1'b0;
        end else begin
            if (active && req && !passed_q)
                lat_q <= 1'b1;
            if (adv && at_dec)
                passed_q <= 1'b1;
        end
    end

    // R8: an armed request stays armed for the rest of the frame
    a_r8_latch_held: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_q && !clr) |=> lat_q);
    // R6: a boundary already passed can never coexist with an armed request
    a_r6_late_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        passed_q |-> !lat_q);
endmodule

// File: rtl/ms_statsh.sv
module ms_statsh #(
    parameter int STAT_W = 56,
    parameter int IDX_W  = $clog2(STAT_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic [STAT_W-1:0] word,
    output logic              bit_o,
    output logic              last
);
    logic [STAT_W-1:0] sh_q;
    logic [IDX_W-1:0]  idx_q;

    assign bit_o = sh_q[0];
    assign last  = (idx_q == IDX_W'(STAT_W - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q  <= '0;
            idx_q <= '0;
        end else if (load) begin
            sh_q  <= word;
            idx_q <= '0;
        end else if (shift) begin
            sh_q  <= sh_q >> 1;
            idx_q <= idx_q + 1'b1;
        end
    end

    // R1: the index never runs past the last status bit
    a_r1_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && last && !load) |=> (idx_q == IDX_W'(STAT_W)) || (idx_q == '0) || shift == 1'b0);
endmodule

// File: rtl/ms_compressor.sv
module ms_compressor
    import ms_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int STAT_BYTES = 7,
    localparam int STAT_W    = 8 * STAT_BYTES,
    localparam int IDX_W     = $clog2(STAT_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_sfd,
    input  logic              rx_vld,
    input  logic              rx_bit,
    input  logic              rx_end,
    input  logic              cmp_req,
    input  logic [CNT_W-1:0]  cmp_dec,
    input  logic [STAT_W-1:0] stat_word,
    output logic              mrx_clk_en,
    output logic              mrx_dat,
    output logic              mcrs
);
    ms_state_e st_q, nxt;

    logic [2:0]       bit_idx;
    logic [CNT_W-1:0] byte_cnt;
    logic             hit, clr, adv, load, shift, st_bit, st_last;

    assign clr   = (st_q == S_IDLE) && frm_sfd;
    assign adv   = (st_q == S_PASS) && !rx_end && rx_vld && !hit;
    assign load  = ((st_q == S_PASS) || (st_q == S_HOLD)) && rx_end;
    assign shift = (st_q == S_STAT);

    ms_bytecnt #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(clr), .adv(adv),
        .bit_idx(bit_idx), .byte_cnt(byte_cnt)
    );

    ms_cmpctl #(.CNT_W(CNT_W)) u_cmp (
        .clk(clk), .rst_n(rst_n), .clr(clr), .active(st_q == S_PASS),
        .adv(adv), .req(cmp_req), .bit_idx(bit_idx), .byte_cnt(byte_cnt),
        .dec(cmp_dec), .hit(hit)
    );

    ms_statsh #(.STAT_W(STAT_W), .IDX_W(IDX_W)) u_stat (
        .clk(clk), .rst_n(rst_n), .load(load), .shift(shift),
        .word(stat_word), .bit_o(st_bit), .last(st_last)
    );

    // next-state logic
    always_comb begin
        nxt = st_q;
        unique case (st_q)
            S_IDLE: if (frm_sfd) nxt = S_PASS;
            S_PASS: begin
                if (rx_end)             nxt = S_STAT;
                else if (rx_vld && hit) nxt = S_HOLD;
            end
            S_HOLD: if (rx_end)  nxt = S_STAT;
            S_STAT: if (st_last) nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= nxt;
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mrx_clk_en <= 1'b0;
            mrx_dat    <= 1'b0;
            mcrs       <= 1'b0;
        end else begin
            mrx_clk_en <= adv || shift;
            mrx_dat    <= adv ? rx_bit : (shift ? st_bit : 1'b0);
            mcrs       <= (st_q != S_IDLE) || (nxt != S_IDLE);
        end
    end

    // R9: a clock pulse is always inside carrier
    a_r9_clk_in_crs: assert property (@(posedge clk) disable iff (!rst_n)
        mrx_clk_en |-> mcrs);
    // R9: carrier drops only right after a clocked (last status) bit
    a_r9_crs_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mcrs) |-> $past(mrx_clk_en));
    // R5: while holding, carrier is up and no clock pulse appears
    a_r5_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_HOLD) |=> (mcrs && !mrx_clk_en));
    // R11: data is zero when not clocked
    a_r11_dat_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !mrx_clk_en |-> !mrx_dat);
endmodule

// File: tb/test_ms_compressor.sv
module test_ms_compressor;
    localparam int CLK_PERIOD = 100;
    localparam int SW = 56;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frm_sfd = 0, rx_vld = 0, rx_bit = 0, rx_end = 0, cmp_req = 0;
    logic [7:0]    cmp_dec = '0;
    logic [SW-1:0] stat_word = '0;
    logic mrx_clk_en, mrx_dat, mcrs;

    int errors = 0, checks = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ms_compressor i_ms_compressor (
        .clk(clk), .rst_n(rst_n), .frm_sfd(frm_sfd), .rx_vld(rx_vld),
        .rx_bit(rx_bit), .rx_end(rx_end), .cmp_req(cmp_req), .cmp_dec(cmp_dec),
        .stat_word(stat_word), .mrx_clk_en(mrx_clk_en), .mrx_dat(mrx_dat), .mcrs(mcrs)
    );

    // behavioural reference model
    int m_st = 0, m_nb = 0, m_k = 0;
    bit m_lat = 0, m_passed = 0;
    bit m_q[$];
    logic e_clk = 0, e_dat = 0, e_crs = 0;
    string e_tag = "R10";

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; e_clk = 0; e_dat = 0; e_crs = 0; e_tag = "R10";
        end else begin
            e_clk = 0; e_dat = 0;
            case (m_st)
                0: begin
                    e_crs = frm_sfd; e_tag = "R9";
                    if (frm_sfd) begin m_st = 1; m_nb = 0; m_lat = 0; m_passed = 0; end
                end
                1: begin
                    e_crs = 1;
                    if (rx_end) begin
                        m_q.delete();
                        for (int i = 0; i < SW; i++) m_q.push_back(stat_word[i]);
                        m_st = 3; m_k = 0; e_tag = "R4";
                    end else begin
                        int bc;
                        bit atd;
                        bc  = (m_nb / 8 > 255) ? 255 : m_nb / 8;
                        atd = (m_nb % 8 == 0) && (bc == int'(cmp_dec));
                        if (cmp_req && !m_passed) m_lat = 1;
                        if (rx_vld) begin
                            if (m_lat && atd) begin m_st = 2; e_tag = "R3"; end
                            else begin
                                e_clk = 1; e_dat = rx_bit; e_tag = "R2";
                                if (atd) m_passed = 1;
                                m_nb++;
                            end
                        end else e_tag = "R11";
                    end
                end
                2: begin
                    e_crs = 1; e_tag = "R5";
                    if (rx_end) begin
                        m_q.delete();
                        for (int i = 0; i < SW; i++) m_q.push_back(stat_word[i]);
                        m_st = 3; m_k = 0;
                    end
                end
                default: begin
                    e_crs = 1; e_clk = 1; e_dat = m_q[m_k]; e_tag = "R1";
                    m_k++;
                    if (m_k == SW) m_st = 0;
                end
            endcase
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // per-cycle comparison, sampled away from the active edge
    always @(negedge clk) begin
        chk({mrx_clk_en, mrx_dat, mcrs} === {e_clk, e_dat, e_crs}, e_tag,
            "outputs {clk_en,dat,crs}", {mrx_clk_en, mrx_dat, mcrs}, {e_clk, e_dat, e_crs});
    end

    // frame-level collector
    int  exp_bits = 0, exp_first = -1;
    string exp_tag = "R4";
    logic [SW-1:0] exp_sw;
    bit got[$];
    bit prev_crs = 0;
    int frames_seen = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (mrx_clk_en) got.push_back(mrx_dat);
            if (prev_crs && !mcrs) begin
                logic [SW-1:0] sw;
                frames_seen++;
                chk(got.size() == exp_bits + SW, exp_tag, "clocked bit count",
                    got.size(), exp_bits + SW);
                if (got.size() >= SW) begin
                    for (int i = 0; i < SW; i++) sw[i] = got[got.size() - SW + i];
                    chk(sw == exp_sw, "R2", "status word LSB first", sw, exp_sw);
                end
                if (exp_first >= 0 && got.size() >= 8) begin
                    logic [7:0] b;
                    for (int i = 0; i < 8; i++) b[i] = got[i];
                    chk(b == exp_first[7:0], "R2", "first data byte", b, exp_first);
                end
                got.delete();
            end
            prev_crs = mcrs;
        end
    end

    function automatic logic [7:0] bval(input int salt, input int i);
        return 8'((i * 37 + salt * 11 + 5) & 255);
    endfunction

    // send one frame; cmp_at < 0 means no request; cmp_len 0 means held to end
    task automatic frame(input int nbytes, input int dec, input int cmp_at,
                         input int cmp_len, input int gap_every,
                         input logic [SW-1:0] sw, input int exp_data_bytes,
                         input string tag, input int salt);
        int held = 0;
        exp_bits  = exp_data_bytes * 8;
        exp_first = (exp_data_bytes > 0) ? int'(bval(salt, 0)) : -1;
        exp_sw    = sw;
        exp_tag   = tag;
        @(negedge clk);
        cmp_dec = 8'(dec); stat_word = sw; frm_sfd = 1;
        @(negedge clk);
        frm_sfd = 0;
        for (int b = 0; b < nbytes * 8; b++) begin
            if (gap_every > 0 && (b % gap_every) == gap_every - 1) begin
                rx_vld = 0;
                @(negedge clk);
            end
            if (cmp_at >= 0 && b == cmp_at) begin cmp_req = 1; held = 0; end
            else if (cmp_req && cmp_len > 0 && held >= cmp_len) cmp_req = 0;
            rx_vld = 1;
            rx_bit = bval(salt, b / 8)[b % 8];
            @(negedge clk);
            held++;
        end
        rx_vld = 0; rx_bit = 0; cmp_req = 0; rx_end = 1;
        @(negedge clk);
        rx_end = 0; stat_word = ~sw;   // status must have been captured at rx_end
        repeat (SW + 6) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk({mrx_clk_en, mrx_dat, mcrs} == 3'b000, "R10", "reset outputs",
            {mrx_clk_en, mrx_dat, mcrs}, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);
        chk(mcrs == 1'b0, "R10", "idle carrier after reset", mcrs, 0);
        // R4: no request, full forward
        frame(10, 3, -1, 0, 0, 56'h0123_4567_89AB_CD, 10, "R4", 1);
        // R3: compress at 4 bytes, request early
        frame(12, 4, 5, 0, 0, 56'hFEDC_BA98_7654_32, 4, "R3", 2);
        // R4: packet ends before boundary
        frame(12, 20, 0, 0, 0, 56'h55AA_33CC_0FF0_81, 12, "R4", 3);
        // R6: request well after boundary
        frame(10, 3, 48, 0, 0, 56'hA5A5_5A5A_C3C3_3C, 10, "R6", 4);
        // R6: request on the boundary bit itself is on time
        frame(10, 3, 24, 0, 0, 56'h1111_2222_3333_44, 3, "R6", 5);
        // R6: request one bit after the boundary is late
        frame(10, 3, 25, 0, 0, 56'h9999_8888_7777_66, 10, "R6", 6);
        // R3: zero decode keeps no data
        frame(6, 0, 0, 0, 0, 56'h00FF_00FF_00FF_00, 0, "R3", 7);
        // R8: one-cycle pulse still compresses
        frame(10, 5, 8, 1, 0, 56'h8000_0000_0000_01, 5, "R8", 8);
        // R11: gaps in valid with compression at 2 bytes
        frame(9, 2, 0, 0, 3, 56'h7E7E_8181_2442_DB, 2, "R11", 9);
        // R7: long frame, late request past saturated boundary
        frame(300, 255, 270 * 8, 0, 0, 56'hCAFE_F00D_BEEF_12, 300, "R7", 10);
        chk(frames_seen == 10, "R9", "carrier drops per frame", frames_seen, 10);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule